// File: doc/BRIEF.md
# Tagged Protection Domain Checker

This block guards a core's load/store path when several processes live in one shared virtual address space. A small table describes address regions. Each region has an inclusive lower and upper bound, an entry address and a protection tag. A register holds the tag of the domain the running thread currently belongs to. Every load or store is checked against the table. It is granted only when the region holding the address carries the thread's current tag. Otherwise it is refused, and a cause code tells a fault handler why.

A thread moves into another domain with a domain-jump request that needs no supervisor help. The jump is honoured only when its target is exactly the entry address registered for the region that holds the target. Otherwise the jump faults and the current tag is left alone. Tag 0 is the supervisor domain and skips the tag comparison. A simple write port lets privileged software fill the table.

Top module: `domain_guard`

## Requirements
- R1: After reset the current tag is 0 and every region entry is invalid, so any access before configuration faults with cause 1 (no region).
- R2: A write on the configuration port (cfg_we high for one cycle) replaces entry cfg_idx with the given bounds, entry address, tag and valid bit, and lookups use the new contents from the next cycle on.
- R3: Each access request produces exactly one response, with rsp_valid high, in the cycle after the request. No response appears without a request. Jump requests behave the same way on the jrsp_* outputs.
- R4: An access whose address lies in a valid region (base <= address <= limit) with tag equal to the current tag is granted with cause 0.
- R5: An access to a valid region whose tag differs from a non-zero current tag is refused with cause 2 (tag mismatch).
- R6: An access that falls in no valid region is refused with cause 1, whatever the current tag. Entries with the valid bit clear never match.
- R7: When regions overlap, only the lowest-numbered matching entry is used, for both accesses and jump targets.
- R8: While the current tag is 0 (supervisor), an access to any valid region is granted, whatever that region's tag.
- R9: A jump whose target lies in a valid region and equals that region's entry address is granted with cause 0. The current tag takes that region's tag in the same cycle the grant appears, so later accesses are checked against it.
- R10: A jump whose target is in no valid region faults with cause 1. A jump whose target is in a region but differs from its entry address faults with cause 3 (bad entry point). In both cases the current tag is unchanged.
- R11: An access issued in the same cycle as a jump is checked against the tag held before the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one region entry |
| cfg_idx | input | IDX_W | Entry number to write |
| cfg_base | input | ADDR_W | Lowest address of the region |
| cfg_limit | input | ADDR_W | Highest address of the region (inclusive) |
| cfg_entry | input | ADDR_W | Registered entry address for jumps |
| cfg_tag | input | TAG_W | Region protection tag |
| cfg_valid | input | 1 | Region enabled |
| acc_valid | input | 1 | Load/store request present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | Store when high, load when low (same check for both) |
| jmp_valid | input | 1 | Domain-jump request present |
| jmp_target | input | ADDR_W | Jump target address |
| rsp_valid | output | 1 | Access response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 2 | Access cause: 0 ok, 1 no region, 2 tag mismatch |
| jrsp_valid | output | 1 | Jump response present |
| jrsp_grant | output | 1 | Jump accepted |
| jrsp_cause | output | 2 | Jump cause: 0 ok, 1 no region, 3 bad entry point |
| cur_tag | output | TAG_W | Current domain tag |

## Verification
A wrong current tag shows in two places. cur_tag differs from the expected value in the cycle the jump response appears. The next access to a region owned by either domain then comes back with the wrong grant and cause 2. A corrupted table entry or a broken priority order shows as a wrong cause code one cycle after the first access or jump that touches the affected range. This includes overlapping ranges, where the bench probes addresses that two entries claim. A lost or duplicated response is caught in the very cycle it should appear, because each expected result is paired with exactly one response.

// File: rtl/dg_pkg.sv
// Shared types for the tagged protection domain checker.
// Assumes a two-bit cause field on both response channels.
package dg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_NO_REGION = 2'd1,
        CAUSE_TAG_MISM  = 2'd2,
        CAUSE_BAD_ENTRY = 2'd3
    } dg_cause_e;
endpackage

// File: rtl/dg_region_table.sv
// Region table storage: NREG entries of bounds, entry address, tag and valid.
// Assumes writes come only from a privileged source; reset clears all entries.
module dg_region_table #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic [ADDR_W-1:0]              base_in,
    input  logic [ADDR_W-1:0]              limit_in,
    input  logic [ADDR_W-1:0]              entry_in,
    input  logic [TAG_W-1:0]               tag_in,
    input  logic                           valid_in,
    output logic [NREG-1:0][ADDR_W-1:0]    base_o,
    output logic [NREG-1:0][ADDR_W-1:0]    limit_o,
    output logic [NREG-1:0][ADDR_W-1:0]    entry_o,
    output logic [NREG-1:0][TAG_W-1:0]     tag_o,
    output logic [NREG-1:0]                valid_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        // Hold one entry; load it when the write targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g]  <= '0;
                limit_o[g] <= '0;
                entry_o[g] <= '0;
                tag_o[g]   <= '0;
                valid_o[g] <= 1'b0;
            end else if (we && idx == IDX_W'(g)) begin
                base_o[g]  <= base_in;
                limit_o[g] <= limit_in;
                entry_o[g] <= entry_in;
                tag_o[g]   <= tag_in;
                valid_o[g] <= valid_in;
            end
        end
    end
endmodule

// File: rtl/dg_region_match.sv
// Priority lookup: finds the lowest-numbered valid entry whose inclusive
// range holds addr. Purely combinational; assumes base <= limit per entry.
module dg_region_match #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic [NREG-1:0][ADDR_W-1:0]    base_i,
    input  logic [NREG-1:0][ADDR_W-1:0]    limit_i,
    input  logic [NREG-1:0][ADDR_W-1:0]    entry_i,
    input  logic [NREG-1:0][TAG_W-1:0]     tag_i,
    input  logic [NREG-1:0]                valid_i,
    input  logic [ADDR_W-1:0]              addr,
    output logic                           hit,
    output logic [TAG_W-1:0]               tag_o,
    output logic [ADDR_W-1:0]              entry_o
);
    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit     = 1'b0;
        tag_o   = '0;
        entry_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (valid_i[i] && addr >= base_i[i] && addr <= limit_i[i]) begin
                hit     = 1'b1;
                tag_o   = tag_i[i];
                entry_o = entry_i[i];
            end
        end
    end
endmodule

// File: rtl/domain_guard.sv
// Tagged protection domain checker. Grants an access when its region's tag
// equals the current tag (tag 0 skips the comparison), and moves the current
// tag on a jump that lands exactly on a region's entry address.
// Assumes one access and one jump per cycle at most; loads and stores are
// checked alike. Responses are registered one cycle after the request.
module domain_guard #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [ADDR_W-1:0] cfg_entry,
    input  logic [TAG_W-1:0]  cfg_tag,
    input  logic              cfg_valid,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              jmp_valid,
    input  logic [ADDR_W-1:0] jmp_target,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [1:0]        rsp_cause,
    output logic              jrsp_valid,
    output logic              jrsp_grant,
    output logic [1:0]        jrsp_cause,
    output logic [TAG_W-1:0]  cur_tag
);
    import dg_pkg::*;

    logic [NREG-1:0][ADDR_W-1:0] t_base, t_limit, t_entry;
    logic [NREG-1:0][TAG_W-1:0]  t_tag;
    logic [NREG-1:0]             t_valid;

    logic              a_hit, j_hit;
    logic [TAG_W-1:0]  a_tag, j_tag;
    logic [ADDR_W-1:0] a_entry, j_entry;
    logic              acc_ok, jmp_ok;
    dg_cause_e         acc_cause, jmp_cause;
    logic              unused_ok;

    assign unused_ok = ^{acc_write, a_entry};

    dg_region_table #(.NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .base_in(cfg_base), .limit_in(cfg_limit), .entry_in(cfg_entry),
        .tag_in(cfg_tag), .valid_in(cfg_valid),
        .base_o(t_base), .limit_o(t_limit), .entry_o(t_entry),
        .tag_o(t_tag), .valid_o(t_valid)
    );

    dg_region_match #(.NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_acc_match (
        .base_i(t_base), .limit_i(t_limit), .entry_i(t_entry), .tag_i(t_tag),
        .valid_i(t_valid), .addr(acc_addr),
        .hit(a_hit), .tag_o(a_tag), .entry_o(a_entry)
    );

    dg_region_match #(.NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_jmp_match (
        .base_i(t_base), .limit_i(t_limit), .entry_i(t_entry), .tag_i(t_tag),
        .valid_i(t_valid), .addr(jmp_target),
        .hit(j_hit), .tag_o(j_tag), .entry_o(j_entry)
    );

    // Decide the access outcome against the tag held before any jump lands.
    always_comb begin
        acc_ok = a_hit && (cur_tag == '0 || a_tag == cur_tag);
        if (!a_hit)      acc_cause = CAUSE_NO_REGION;
        else if (acc_ok) acc_cause = CAUSE_NONE;
        else             acc_cause = CAUSE_TAG_MISM;
    end

    // Decide the jump outcome: target must equal the matched entry address.
    always_comb begin
        jmp_ok = j_hit && (jmp_target == j_entry);
        if (!j_hit)      jmp_cause = CAUSE_NO_REGION;
        else if (jmp_ok) jmp_cause = CAUSE_NONE;
        else             jmp_cause = CAUSE_BAD_ENTRY;
    end

    // Register responses and move the current tag on an accepted jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_cause  <= CAUSE_NONE;
            jrsp_valid <= 1'b0;
            jrsp_grant <= 1'b0;
            jrsp_cause <= CAUSE_NONE;
            cur_tag    <= '0;
        end else begin
            rsp_valid  <= acc_valid;
            rsp_grant  <= acc_valid && acc_ok;
            rsp_cause  <= acc_valid ? acc_cause : CAUSE_NONE;
            jrsp_valid <= jmp_valid;
            jrsp_grant <= jmp_valid && jmp_ok;
            jrsp_cause <= jmp_valid ? jmp_cause : CAUSE_NONE;
            if (jmp_valid && jmp_ok) cur_tag <= j_tag;
        end
    end
endmodule

// File: rtl/dg_checker.sv
// Port-level properties of domain_guard, attached with bind.
// Assumes the synchronous active-low reset of the checked block.
module dg_checker #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             jmp_valid,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [1:0]       rsp_cause,
    input logic             jrsp_valid,
    input logic             jrsp_grant,
    input logic [1:0]       jrsp_cause,
    input logic [TAG_W-1:0] cur_tag
);
    assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    assert_jrsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |=> jrsp_valid);
    assert_grant_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> rsp_cause == 2'd0);
    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (rsp_cause == 2'd1 || rsp_cause == 2'd2));
    assert_jump_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (jrsp_valid && !jrsp_grant) |-> (jrsp_cause == 2'd1 || jrsp_cause == 2'd3));
    assert_tag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(jrsp_valid && jrsp_grant) |-> cur_tag == $past(cur_tag));
endmodule

bind domain_guard dg_checker #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .jmp_valid(jmp_valid),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_cause(rsp_cause),
    .jrsp_valid(jrsp_valid), .jrsp_grant(jrsp_grant), .jrsp_cause(jrsp_cause),
    .cur_tag(cur_tag)
);

// File: tb/sim_domain_guard.sv
// Scoreboard bench: the driver computes expected results from a table model
// and queues them; the monitor pairs each with the response a cycle later.
module sim_domain_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0, cfg_limit = '0, cfg_entry = '0;
    logic [3:0]  cfg_tag = '0;
    logic        cfg_valid = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        jmp_valid = 1'b0;
    logic [15:0] jmp_target = '0;
    logic        rsp_valid, rsp_grant, jrsp_valid, jrsp_grant;
    logic [1:0]  rsp_cause, jrsp_cause;
    logic [3:0]  cur_tag;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit         grant;
        logic [1:0] cause;
        logic [3:0] tag_after;
        string      req;
    } exp_t;
    exp_t acc_q[$];
    exp_t jmp_q[$];

    logic [15:0] m_base[8], m_lim[8], m_ent[8];
    logic [3:0]  m_tag[8];
    bit          m_val[8];
    logic [3:0]  m_cur = '0;

    always #10 clk = ~clk;

    domain_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_entry(cfg_entry),
        .cfg_tag(cfg_tag), .cfg_valid(cfg_valid), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .jmp_valid(jmp_valid),
        .jmp_target(jmp_target), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_cause(rsp_cause), .jrsp_valid(jrsp_valid), .jrsp_grant(jrsp_grant),
        .jrsp_cause(jrsp_cause), .cur_tag(cur_tag)
    );

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
        end
    endtask

    // Lowest-numbered valid region holding a, or -1 (R7).
    function automatic int find(logic [15:0] a);
        for (int i = 7; i >= 0; i--) begin
            if (m_val[i] && a >= m_base[i] && a <= m_lim[i]) find = i;
        end
        for (int i = 0; i < 8; i++) begin
            if (m_val[i] && a >= m_base[i] && a <= m_lim[i]) return i;
        end
        return -1;
    endfunction

    task automatic cfg(int idx, logic [15:0] b, logic [15:0] l, logic [15:0] e,
                       logic [3:0] t, bit v);
        @(negedge clk);
        acc_valid = 1'b0; jmp_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_limit = l;
        cfg_entry = e; cfg_tag = t; cfg_valid = v;
        m_base[idx] = b; m_lim[idx] = l; m_ent[idx] = e; m_tag[idx] = t; m_val[idx] = v;
    endtask

    // Drive one cycle of requests and queue the expected responses.
    task automatic step(bit av, logic [15:0] aa, string ra,
                        bit jv, logic [15:0] jt, string rj);
        exp_t e;
        int   i;
        @(negedge clk);
        cfg_we = 1'b0;
        acc_valid = av; acc_addr = aa; acc_write = aa[0];
        jmp_valid = jv; jmp_target = jt;
        if (av) begin
            i = find(aa);
            e.req = ra; e.tag_after = m_cur;
            if (i < 0) begin e.grant = 0; e.cause = 2'd1; end
            else if (m_cur == 4'd0 || m_tag[i] == m_cur) begin e.grant = 1; e.cause = 2'd0; end
            else begin e.grant = 0; e.cause = 2'd2; end
            acc_q.push_back(e);
        end
        if (jv) begin
            i = find(jt);
            e.req = rj;
            if (i < 0) begin e.grant = 0; e.cause = 2'd1; e.tag_after = m_cur; end
            else if (jt == m_ent[i]) begin e.grant = 1; e.cause = 2'd0; e.tag_after = m_tag[i]; end
            else begin e.grant = 0; e.cause = 2'd3; e.tag_after = m_cur; end
            jmp_q.push_back(e);
            m_cur = e.tag_after;
        end
    endtask

    task automatic acc(logic [15:0] a, string r);
        step(1'b1, a, r, 1'b0, 16'h0, "");
    endtask

    task automatic jmp(logic [15:0] t, string r);
        step(1'b0, 16'h0, "", 1'b1, t, r);
    endtask

    // Monitor: pair each response with the oldest expected item (R3).
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (acc_q.size() > 0) begin
                    e = acc_q.pop_front();
                    chk(e.req, "rsp_valid", 32'(rsp_valid), 32'd1);
                    chk(e.req, "rsp_grant", 32'(rsp_grant), 32'(e.grant));
                    chk(e.req, "rsp_cause", 32'(rsp_cause), 32'(e.cause));
                end else if (rsp_valid) begin
                    chk("R3", "unexpected rsp_valid", 32'd1, 32'd0);
                end
                if (jmp_q.size() > 0) begin
                    e = jmp_q.pop_front();
                    chk(e.req, "jrsp_valid", 32'(jrsp_valid), 32'd1);
                    chk(e.req, "jrsp_grant", 32'(jrsp_grant), 32'(e.grant));
                    chk(e.req, "jrsp_cause", 32'(jrsp_cause), 32'(e.cause));
                    chk(e.req, "cur_tag", 32'(cur_tag), 32'(e.tag_after));
                end else if (jrsp_valid) begin
                    chk("R3", "unexpected jrsp_valid", 32'd1, 32'd0);
                end
            end
        end
    end

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_val[i] = 0; m_base[i] = '0; m_lim[i] = '0; m_ent[i] = '0; m_tag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cur_tag after reset", 32'(cur_tag), 32'd0);
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1", "jrsp_valid after reset", 32'(jrsp_valid), 32'd0);
        acc(16'h0100, "R1");              // empty table: cause 1

        cfg(0, 16'h1000, 16'h1FFF, 16'h1000, 4'd1, 1'b1);
        cfg(1, 16'h2000, 16'h2FFF, 16'h2040, 4'd2, 1'b1);
        cfg(2, 16'h1800, 16'h27FF, 16'h1800, 4'd3, 1'b1);   // overlaps 0 and 1
        cfg(3, 16'h4000, 16'h4FFF, 16'h4000, 4'd2, 1'b0);   // disabled

        acc(16'h1000, "R8");              // supervisor: any tag granted
        acc(16'h2100, "R8");
        acc(16'h4100, "R6");              // disabled entry never matches
        acc(16'h3000, "R6");
        jmp(16'h1004, "R10");             // inside region 0, not its entry
        jmp(16'h5000, "R10");             // no region
        step(1'b1, 16'h2100, "R11", 1'b1, 16'h1000, "R9");  // access sees tag 0
        acc(16'h1000, "R9");              // new tag 1 now in force
        acc(16'h2100, "R5");
        acc(16'h1900, "R7");              // region 0 beats region 2
        acc(16'h2000, "R7");              // region 1 beats region 2
        acc(16'h1FFF, "R4");              // upper bound inclusive
        acc(16'h3000, "R6");
        jmp(16'h2040, "R9");              // to tag 2
        acc(16'h2000, "R4");
        acc(16'h1900, "R5");
        jmp(16'h1800, "R7");              // region 0 wins, entry 0x1000: bad entry
        acc(16'h2FFF, "R4");

        cfg(3, 16'h4000, 16'h4FFF, 16'h4000, 4'd2, 1'b1);   // enable entry 3
        acc(16'h4100, "R2");
        acc(16'h4FFF, "R2");
        acc(16'h5000, "R6");
        step(1'b0, 16'h0, "", 1'b0, 16'h0, "");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule